// File: doc/BRIEF.md
# Multi-function pin mux cell

This cell holds the full configuration of one chip pad in a single 32-bit register that software loads over a plain write strobe. A three-bit select in that register picks one of eight on-chip functions; the chosen function drives the pad's output data, output enable and pull request, and only that function sees the pad's input level. The register also supplies the pad's drive-strength code and decides where the pull comes from: either the selected function or two register bits.

During low-power mode the register can take over the pad. When its sleep-select bit is set, it replaces the function's output enable and data with fixed values of its own. Independently of the mux, the cell synchronises the pad level and looks for rising or falling transitions, or both. It latches any detected transition in a sticky flag, and it raises a wakeup request while that flag is set and the external wake-enable input is high.

Top module: `pin_mux_cell`

## Requirements
- R1: A write with `cfg_we` high stores `cfg_wdata` masked with 0x0000FFF7 on the next rising clock edge. `cfg_rdata` always shows the stored value, so bit 3 and bits 31:16 read as zero. After reset the register reads 0x00000800.
- R2: Bits 2:0 select function `s`. When the low-power override is not active, `pad_out` equals `fn_out[s]` and `pad_oe` equals `fn_oe[s]`. `fn_in[s]` equals `pad_in` and every other `fn_in` bit is 0.
- R3: With bit 4 set and bit 6 clear, a 0-to-1 change on `pad_in` sets `edge_flag` at the third rising edge after the change and not before. A 1-to-0 change does not set it when bit 5 is clear.
- R4: With bit 5 set and bit 6 clear, a 1-to-0 change on `pad_in` sets `edge_flag` at the third rising edge after the change. With bits 4 and 5 both set, either direction sets it.
- R5: `edge_flag` stays set once set. It clears at the clock edge that performs any register write. While bit 6 is set, the flag is held at 0 and no transition sets it.
- R6: With bit 15 at 0, `pad_pu` and `pad_pd` follow `fn_pull_up[s]` and `fn_pull_dn[s]`. With bit 15 at 1, bit 14 requests pull-up and bit 13 requests pull-down. In both cases, if both are requested, only `pad_pd` is driven high.
- R7: `pad_drive` equals register bits 12:10.
- R8: When `lp_mode` is high and bit 9 is set, `pad_oe` equals the inverse of bit 7 and `pad_out` equals bit 8. Otherwise the selected function drives both.
- R9: `wake_req` is high exactly when `edge_flag` and `wake_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register contents |
| fn_out | input | 8 | Output data from each function |
| fn_oe | input | 8 | Output enable from each function |
| fn_pull_up | input | 8 | Pull-up request from each function |
| fn_pull_dn | input | 8 | Pull-down request from each function |
| fn_in | output | 8 | Pad input returned to the selected function |
| lp_mode | input | 1 | Low-power mode active |
| wake_en | input | 1 | External wake enable |
| pad_in | input | 1 | Pad input level |
| pad_out | output | 1 | Pad output data |
| pad_oe | output | 1 | Pad output enable |
| pad_pu | output | 1 | Pad pull-up enable |
| pad_pd | output | 1 | Pad pull-down enable |
| pad_drive | output | 3 | Drive strength and slew code |
| edge_flag | output | 1 | Sticky edge-detected status |
| wake_req | output | 1 | Wakeup request |

## Verification
The mux, pull, drive, low-power and wake outputs are combinational from the register and the inputs, so they are due one clock edge after a register write, or at once after a plain input change. The bench sweeps every select value, pull combination, drive code and override combination, and checks each result on the falling edge after its write. Edge status has a three-edge latency: two synchroniser stages and the flag register. The bench therefore checks the flag both after two edges, when it must still be low, and after three, when it must be set. Before each register write, the bench waits until the pad level has fully passed through the synchroniser.

// File: rtl/pin_mux_cell.sv
module pin_mux_cell #(
  parameter logic [31:0] RESET_CFG = 32'h0000_0800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic [7:0]  fn_out,
  input  logic [7:0]  fn_oe,
  input  logic [7:0]  fn_pull_up,
  input  logic [7:0]  fn_pull_dn,
  output logic [7:0]  fn_in,
  input  logic        lp_mode,
  input  logic        wake_en,
  input  logic        pad_in,
  output logic        pad_out,
  output logic        pad_oe,
  output logic        pad_pu,
  output logic        pad_pd,
  output logic [2:0]  pad_drive,
  output logic        edge_flag,
  output logic        wake_req
);
  localparam logic [31:0] WMASK = 32'h0000_FFF7;

  logic [31:0] cfg_q;
  logic [2:0]  sel;
  logic        rise_en, fall_en, det_off, slp_oe_n, slp_dat, slp_sel;
  logic        pd_reg, pu_reg, pull_reg;
  logic        sync1, sync2, last;
  logic        hit, pu_req, pd_req, override;

  assign sel      = cfg_q[2:0];
  assign rise_en  = cfg_q[4];
  assign fall_en  = cfg_q[5];
  assign det_off  = cfg_q[6];
  assign slp_oe_n = cfg_q[7];
  assign slp_dat  = cfg_q[8];
  assign slp_sel  = cfg_q[9];
  assign pd_reg   = cfg_q[13];
  assign pu_reg   = cfg_q[14];
  assign pull_reg = cfg_q[15];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= RESET_CFG & WMASK;
    else if (cfg_we) cfg_q <= cfg_wdata & WMASK;

  assign cfg_rdata = cfg_q;
  assign pad_drive = cfg_q[12:10];

  assign override = lp_mode & slp_sel;
  assign pad_oe   = override ? ~slp_oe_n : fn_oe[sel];
  assign pad_out  = override ? slp_dat   : fn_out[sel];
  assign fn_in    = {8{pad_in}} & (8'd1 << sel);

  assign pd_req = pull_reg ? pd_reg : fn_pull_dn[sel];
  assign pu_req = pull_reg ? pu_reg : fn_pull_up[sel];
  assign pad_pd = pd_req;
  assign pad_pu = pu_req & ~pd_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {sync1, sync2, last} <= '0;
    else        {sync1, sync2, last} <= {pad_in, sync1, sync2};

  assign hit = ~det_off & ((rise_en & sync2 & ~last) | (fall_en & ~sync2 & last));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 edge_flag <= 1'b0;
    else if (cfg_we || det_off) edge_flag <= 1'b0;
    else if (hit)               edge_flag <= 1'b1;

  assign wake_req = edge_flag & wake_en;

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));
  p_rise_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_flag) |-> ($past(cfg_rdata[4]) || $past(cfg_rdata[5])));
  p_clear_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[6] |=> !edge_flag);
  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !edge_flag);
  p_pull_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pad_pu && pad_pd));
  p_wake_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (wake_en && edge_flag));
endmodule

// File: tb/tb_pin_mux_cell.sv
module tb_pin_mux_cell;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [7:0]  fn_out = '0, fn_oe = '0, fn_pull_up = '0, fn_pull_dn = '0;
  logic [7:0]  fn_in;
  logic        lp_mode = 1'b0, wake_en = 1'b0, pad_in = 1'b0;
  logic        pad_out, pad_oe, pad_pu, pad_pd, edge_flag, wake_req;
  logic [2:0]  pad_drive;
  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  pin_mux_cell dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(2); rst_n = 1'b1; cyc(1);
    chk("R1 reset value", cfg_rdata, 32'h0000_0800);
    chk("R7 reset drive", {29'd0, pad_drive}, 32'd2);
    chk("R5 reset flag", {31'd0, edge_flag}, 32'd0);

    // R1 masking
    wr(32'hFFFF_FFFF); chk("R1 reserved zero", cfg_rdata, 32'h0000_FFF7);
    wr(32'hA5A5_1234); chk("R1 readback", cfg_rdata, 32'hA5A5_1234 & 32'h0000_FFF7);
    wr(32'h0000_0000);

    // R2 select sweep
    for (int s = 0; s < 8; s++) begin
      wr(32'(s));
      for (int p = 0; p < 2; p++) begin
        fn_out = p ? 8'h5A : 8'hC3; fn_oe = ~fn_out; pad_in = p[0];
        #1;
        chk("R2 pad_out", {31'd0, pad_out}, {31'd0, fn_out[s]});
        chk("R2 pad_oe", {31'd0, pad_oe}, {31'd0, fn_oe[s]});
        chk("R2 fn_in", {24'd0, fn_in}, {24'd0, 8'(p) << s});
      end
    end
    pad_in = 1'b0; cyc(3);

    // R6 pull sweep, function 3
    for (int m = 0; m < 32; m++) begin
      fn_pull_up = m[3] ? 8'h08 : 8'h00;
      fn_pull_dn = m[4] ? 8'h08 : 8'h00;
      wr(32'd3 | (32'(m[0]) << 15) | (32'(m[1]) << 14) | (32'(m[2]) << 13));
      begin
        logic epd, epu;
        epd = m[0] ? m[2] : m[4];
        epu = (m[0] ? m[1] : m[3]) & ~epd;
        chk("R6 pad_pd", {31'd0, pad_pd}, {31'd0, epd});
        chk("R6 pad_pu", {31'd0, pad_pu}, {31'd0, epu});
      end
    end

    // R7 drive sweep
    for (int d = 0; d < 8; d++) begin
      wr(32'(d) << 10);
      chk("R7 pad_drive", {29'd0, pad_drive}, 32'(d));
    end

    // R8 low-power override sweep, function 0
    for (int m = 0; m < 16; m++) begin
      wr((32'(m[1]) << 9) | (32'(m[2]) << 7) | (32'(m[3]) << 8));
      lp_mode = m[0]; fn_out = {7'd0, ~m[2]}; fn_oe = {7'd0, m[3]};
      #1;
      if (m[0] && m[1]) begin
        chk("R8 override oe", {31'd0, pad_oe}, {31'd0, ~m[2]});
        chk("R8 override out", {31'd0, pad_out}, {31'd0, m[3]});
      end else begin
        chk("R8 function oe", {31'd0, pad_oe}, {31'd0, fn_oe[0]});
        chk("R8 function out", {31'd0, pad_out}, {31'd0, fn_out[0]});
      end
    end
    lp_mode = 1'b0;

    // R3 rising edge latency and wake gating
    wr(32'h10); pad_in = 1'b1;
    cyc(2); chk("R3 not before 3rd edge", {31'd0, edge_flag}, 32'd0);
    cyc(1); chk("R3 rise sets flag", {31'd0, edge_flag}, 32'd1);
    chk("R9 wake gated off", {31'd0, wake_req}, 32'd0);
    wake_en = 1'b1; #1;
    chk("R9 wake on", {31'd0, wake_req}, 32'd1);
    pad_in = 1'b0; cyc(3);
    chk("R5 sticky", {31'd0, edge_flag}, 32'd1);
    wr(32'h10); chk("R5 write clears", {31'd0, edge_flag}, 32'd0);
    chk("R9 wake follows flag", {31'd0, wake_req}, 32'd0);
    pad_in = 1'b1; cyc(3); wr(32'h10);
    pad_in = 1'b0; cyc(3);
    chk("R3 fall ignored", {31'd0, edge_flag}, 32'd0);

    // R4 falling and both
    wr(32'h20); pad_in = 1'b1; cyc(3);
    chk("R4 rise ignored", {31'd0, edge_flag}, 32'd0);
    pad_in = 1'b0;
    cyc(2); chk("R4 not before 3rd edge", {31'd0, edge_flag}, 32'd0);
    cyc(1); chk("R4 fall sets flag", {31'd0, edge_flag}, 32'd1);
    wr(32'h30); chk("R5 clear on write", {31'd0, edge_flag}, 32'd0);
    pad_in = 1'b1; cyc(3);
    chk("R4 both rise", {31'd0, edge_flag}, 32'd1);
    wr(32'h30); pad_in = 1'b0; cyc(3);
    chk("R4 both fall", {31'd0, edge_flag}, 32'd1);

    // R5 edge-clear bit blocks detection
    wr(32'h70); chk("R5 bit6 clears", {31'd0, edge_flag}, 32'd0);
    pad_in = 1'b1; cyc(3);
    chk("R5 bit6 blocks rise", {31'd0, edge_flag}, 32'd0);
    pad_in = 1'b0; cyc(3);
    chk("R5 bit6 blocks fall", {31'd0, edge_flag}, 32'd0);
    chk("R9 no wake", {31'd0, wake_req}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule